// File: doc/BRIEF.md
# Microwire EEPROM Address Loader

The loader fetches a 32-byte configuration image from a 4-wire Microwire serial EEPROM and derives a 48-bit station address from it. A single start pulse makes it read all sixteen 16-bit words. Each word gets its own chip-select cycle and its own read command. Every serial step is held for a programmable number of clock cycles, so the serial clock can be slowed to suit the memory.

Once the last word is in, the loader XORs the bytes of a key region and compares the result with a stored check byte. On a match it copies six consecutive image bytes to the station address output. On a mismatch it raises an error flag and keeps the previous address. A done flag reports the end of each load. The key start, the check-byte index and the address offset are parameters.

Top module: `mw_addr_loader`

## Requirements
- R1: While reset is high and in the cycle after it, chip select, serial clock, data-in, busy, done and csum_err are 0 and station_addr is all zeros.
- R2: A start pulse while idle raises busy and begins a load. A start pulse while busy is ignored: the load in progress keeps its word sequence and still performs exactly sixteen transactions.
- R3: Each word transaction raises chip select and then sends ten bits on data-in, each latched on a rising serial clock edge. The bits are one dummy 0, then 1, 1, 0 (start bit and read opcode), then a 6-bit word address, most significant bit first. The address counts 0 to 15 over one load.
- R4: Each serial clock high phase lasts exactly half_div+1 cycles. Data-in never changes while the serial clock is high, and the serial clock is high only while chip select is high.
- R5: After the command, sixteen data bits are clocked in, most significant bit first. Each bit is sampled at the end of the low phase that follows its rising edge. Word k becomes image byte 2k (its upper 8 bits) and byte 2k+1 (its lower 8 bits).
- R6: Chip select goes low between words and stays low whenever the loader is not busy. A load consists of exactly sixteen chip-select cycles.
- R7: When the XOR of image bytes KEY_IDX up to CSUM_IDX-1 equals byte CSUM_IDX, station_addr takes bytes ADDR_OFF..ADDR_OFF+5. The first byte goes to bits 47:40 and the last to bits 7:0, and csum_err is 0.
- R8: On a checksum mismatch, csum_err is 1 and station_addr keeps its previous value.
- R9: done rises when a load ends, together with a valid csum_err. done stays high until the next accepted start, and busy is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a load |
| half_div | input | DIV_W | Cycles per serial half-bit, minus one |
| eep_do | input | 1 | Serial data from the EEPROM |
| eep_cs | output | 1 | EEPROM chip select |
| eep_sk | output | 1 | EEPROM serial clock |
| eep_di | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load finished |
| csum_err | output | 1 | Last load failed its checksum |
| station_addr | output | 48 | Extracted station address |

## Verification
The assertions assume that half_div stays constant during a load. They also assume that eep_do changes only after a rising serial clock edge, so that it is stable when sampled at the end of the low phase. The bench changes half_div only between loads. Its EEPROM model drives data one nanosecond after each rising serial clock edge, well before the end of the following low phase. Extra start pulses are applied only in the middle of a load, where R2 requires them to have no effect.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int CMD_BITS  = 10;
    localparam int WADDR_W   = 6;
    localparam int WORD_W    = 16;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SEL, PH_CMD, PH_GAP, PH_READ, PH_END
    } phase_t;

    typedef enum logic [1:0] {
        T_IDLE, T_WORD, T_CHECK
    } top_t;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pins_t;

    // dummy bit, start bit, read opcode, then the word address
    function automatic logic [CMD_BITS-1:0] read_cmd(input logic [WADDR_W-1:0] a);
        return {4'b0110, a};
    endfunction
endpackage

// File: rtl/mw_slot_timer.sv
module mw_slot_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || cnt == '0) cnt <= half_div;
        else                          cnt <= cnt - 1'b1;
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/mw_word_engine.sv
module mw_word_engine
    import mw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                tick,
    input  logic [WADDR_W-1:0]  waddr,
    input  logic                sdo,
    output pins_t               pins,
    output logic                active,
    output logic                word_done,
    output logic [WORD_W-1:0]   word_data
);
    localparam int CNT_W = $clog2(WORD_W);

    phase_t             phase;
    logic [CNT_W-1:0]   cnt;
    logic               hi;
    logic [CMD_BITS-1:0] cmd;

    assign cmd = read_cmd(waddr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            hi        <= 1'b0;
            word_done <= 1'b0;
            word_data <= '0;
        end else begin
            word_done <= 1'b0;
            case (phase)
                PH_IDLE: if (go) phase <= PH_SEL;
                PH_SEL: if (tick) begin
                    phase <= PH_CMD;
                    cnt   <= '0;
                    hi    <= 1'b0;
                end
                PH_CMD: if (tick) begin
                    if (!hi) hi <= 1'b1;
                    else begin
                        hi <= 1'b0;
                        if (cnt == CNT_W'(CMD_BITS-1)) phase <= PH_GAP;
                        else cnt <= cnt + 1'b1;
                    end
                end
                PH_GAP: if (tick) begin
                    phase <= PH_READ;
                    cnt   <= '0;
                    hi    <= 1'b1;
                end
                PH_READ: if (tick) begin
                    if (hi) hi <= 1'b0;
                    else begin
                        word_data <= {word_data[WORD_W-2:0], sdo};
                        hi        <= 1'b1;
                        if (cnt == CNT_W'(WORD_W-1)) begin
                            phase <= PH_END;
                            hi    <= 1'b0;
                        end else cnt <= cnt + 1'b1;
                    end
                end
                PH_END: if (tick) begin
                    phase     <= PH_IDLE;
                    word_done <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign active  = (phase != PH_IDLE);
    assign pins.cs = (phase != PH_IDLE) && (phase != PH_SEL);
    assign pins.sk = ((phase == PH_CMD) || (phase == PH_READ)) && hi;
    assign pins.di = (phase == PH_CMD) ? cmd[CMD_BITS-1-int'(cnt)] : 1'b0;

    // R4
    sk_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
        pins.sk |-> pins.cs);

    // R4
    di_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pins.sk && $past(pins.sk)) |-> $stable(pins.di));

    // R6
    cs_drop_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |-> !pins.cs);
endmodule

// File: rtl/mw_addr_loader.sv
module mw_addr_loader
    import mw_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int N_BYTES  = 32,
    parameter int KEY_IDX  = 0,
    parameter int CSUM_IDX = 31,
    parameter int ADDR_OFF = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic             eep_do,
    output logic             eep_cs,
    output logic             eep_sk,
    output logic             eep_di,
    output logic             busy,
    output logic             done,
    output logic             csum_err,
    output logic [47:0]      station_addr
);
    localparam int N_WORDS = N_BYTES / 2;
    localparam int WIDX_W  = $clog2(N_WORDS);
    localparam int ADDR_BYTES = 6;

    top_t              state;
    logic [WIDX_W-1:0] widx;
    logic              go;
    logic              tick, eng_active, word_done;
    logic [WORD_W-1:0] word_data;
    pins_t             pins;
    logic [7:0]        img [N_BYTES];
    logic [7:0]        xsum;
    logic [47:0]       addr_nxt;

    mw_slot_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst(rst), .run(eng_active), .half_div(half_div), .tick(tick)
    );

    mw_word_engine u_engine (
        .clk(clk), .rst(rst), .go(go), .tick(tick),
        .waddr(WADDR_W'(widx)), .sdo(eep_do), .pins(pins),
        .active(eng_active), .word_done(word_done), .word_data(word_data)
    );

    always_comb begin
        xsum = '0;
        for (int i = KEY_IDX; i < CSUM_IDX; i++) xsum ^= img[i];
        for (int i = 0; i < ADDR_BYTES; i++)
            addr_nxt[47-8*i -: 8] = img[ADDR_OFF+i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= T_IDLE;
            widx         <= '0;
            go           <= 1'b0;
            done         <= 1'b0;
            csum_err     <= 1'b0;
            station_addr <= '0;
            for (int i = 0; i < N_BYTES; i++) img[i] <= '0;
        end else begin
            go <= 1'b0;
            case (state)
                T_IDLE: if (start) begin
                    state    <= T_WORD;
                    widx     <= '0;
                    go       <= 1'b1;
                    done     <= 1'b0;
                    csum_err <= 1'b0;
                end
                T_WORD: if (word_done) begin
                    img[{widx, 1'b0}] <= word_data[15:8];
                    img[{widx, 1'b1}] <= word_data[7:0];
                    if (widx == WIDX_W'(N_WORDS-1)) state <= T_CHECK;
                    else begin
                        widx <= widx + 1'b1;
                        go   <= 1'b1;
                    end
                end
                T_CHECK: begin
                    state    <= T_IDLE;
                    done     <= 1'b1;
                    csum_err <= (xsum != img[CSUM_IDX]);
                    if (xsum == img[CSUM_IDX]) station_addr <= addr_nxt;
                end
                default: state <= T_IDLE;
            endcase
        end
    end

    assign busy   = (state != T_IDLE);
    assign eep_cs = pins.cs;
    assign eep_sk = pins.sk;
    assign eep_di = pins.di;

    // R6
    idle_cs_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eep_cs);

    // R2
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && state == T_WORD && !word_done) |=> (busy && $stable(widx)));

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        csum_err |-> done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/tb_mw_addr_loader.sv
module tb_mw_addr_loader;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DIV_W-1:0] half_div = 8'd1;
    logic eep_do = 1'b0;
    logic eep_cs, eep_sk, eep_di, busy, done, csum_err;
    logic [47:0] station_addr;

    int total = 0;
    int bad = 0;

    mw_addr_loader dut (
        .clk(clk), .rst(rst), .start(start), .half_div(half_div), .eep_do(eep_do),
        .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_di(eep_di), .busy(busy),
        .done(done), .csum_err(csum_err), .station_addr(station_addr)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural EEPROM
    logic [7:0] img [32];
    int nbits = 0;
    int exp_word = 0;
    int n_trans = 0;
    logic [9:0] cmdsh = '0;
    int cur_addr = 0;

    always @(posedge eep_cs) begin
        nbits = 0;
        n_trans++;
    end

    always @(posedge eep_sk) begin
        if (nbits < 10) begin
            cmdsh = {cmdsh[8:0], eep_di};
            nbits++;
            if (nbits == 10) begin
                // R3
                check(cmdsh[9:6] == 4'b0110, "R3 opcode", 64'(cmdsh[9:6]), 64'h6);
                check(int'(cmdsh[5:0]) == exp_word, "R3 word address", 64'(cmdsh[5:0]), 64'(exp_word));
                cur_addr = int'(cmdsh[5:0]) & 15;
                exp_word++;
            end
        end else begin
            automatic int k = nbits - 10;
            automatic logic [15:0] w = {img[2*cur_addr], img[2*cur_addr+1]};
            nbits++;
            #1 eep_do = (k < 16) ? w[15-k] : 1'b0;
        end
    end

    // per-clock protocol model
    int hi_len = 0;
    always @(negedge clk) begin
        if (!rst) begin
            // R6
            if (!busy) check(!eep_cs, "R6 cs low while idle", 64'(eep_cs), 0);
            // R4
            if (eep_sk) check(eep_cs, "R4 sk needs cs", 64'(eep_cs), 1);
            if (eep_sk) hi_len++;
            else if (hi_len != 0) begin
                check(hi_len == int'(half_div) + 1, "R4 sk high width", 64'(hi_len), 64'(int'(half_div) + 1));
                hi_len = 0;
            end
        end
    end

    function automatic logic [7:0] key_xor();
        logic [7:0] s = '0;
        for (int i = 0; i < 31; i++) s ^= img[i];
        return s;
    endfunction

    function automatic logic [47:0] img_addr();
        logic [47:0] a;
        for (int i = 0; i < 6; i++) a[47-8*i -: 8] = img[16+i];
        return a;
    endfunction

    bit hung = 0;

    task automatic run_load(input logic [DIV_W-1:0] div, input bit poke_start,
                            input bit exp_err, input logic [47:0] exp_addr);
        int cyc = 0;
        half_div = div;
        exp_word = 0;
        n_trans = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R2
        check(busy && !done, "R2 busy after start", 64'({busy, done}), 64'h2);
        if (poke_start) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            hung = 1;
            check(0, "watchdog", 0, 1);
        end
        // R6 R2
        check(n_trans == 16, "R6 R2 transactions per load", 64'(n_trans), 16);
        // R9
        check(!busy, "R9 not busy at done", 64'(busy), 0);
        // R7 R8
        check(csum_err == exp_err, "R7 R8 checksum flag", 64'(csum_err), 64'(exp_err));
        // R5 R7 R8
        check(station_addr == exp_addr, "R5 R7 R8 station address", 64'(station_addr), 64'(exp_addr));
        repeat (10) @(negedge clk);
        // R9
        check(done && !eep_cs, "R9 done holds", 64'({done, eep_cs}), 64'h2);
    endtask

    initial begin
        logic [47:0] a1;
        repeat (3) @(negedge clk);
        // R1
        check(!eep_cs && !eep_sk && !eep_di, "R1 pins in reset", 64'({eep_cs, eep_sk, eep_di}), 0);
        check(!busy && !done && !csum_err, "R1 flags in reset", 64'({busy, done, csum_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(station_addr == '0, "R1 address after reset", 64'(station_addr), 0);
        check(!busy && !done, "R1 idle after reset", 64'({busy, done}), 0);

        // good image, divider 1, extra start mid-load
        for (int i = 0; i < 32; i++) img[i] = 8'(i * 37 + 5);
        img[31] = key_xor();
        a1 = img_addr();
        if (!hung) run_load(8'd1, 1'b1, 1'b0, a1);

        // corrupted check byte, divider 0: address must hold
        for (int i = 0; i < 32; i++) img[i] = 8'(i * 91 + 200);
        img[31] = key_xor() ^ 8'h5A;
        if (!hung) run_load(8'd0, 1'b0, 1'b1, a1);

        // good image with extreme bit patterns, divider 3
        for (int i = 0; i < 32; i++) img[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
        img[16] = 8'h80; img[21] = 8'h01;
        img[31] = key_xor();
        if (!hung) run_load(8'd3, 1'b0, 1'b0, img_addr());

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule